// File: doc/BRIEF.md
# Dual-Access Machine Timer

This block keeps the 64-bit machine time value and a 64-bit deadline for a RISC-V core running in machine mode, and raises a level-sensitive timer interrupt request whenever the time value has reached or passed the deadline. The time value advances by one on every clock cycle in which the tick-enable input is high. A clock-rate divider or a fixed-rate strobe therefore sets its pace.

Software reaches each 64-bit register as two 32-bit words. A build-time parameter decides how the block is reached. In one build it is a word-addressed memory-mapped slave. In the other it is a CSR-numbered port with read and write strobes. The port that is not selected is ignored.

A write to the time value never exposes a half-updated 64-bit number. Each half that software writes is held in a staging buffer. The full value is loaded in one cycle only when the second half arrives, and the two halves may come in either order. Deadline words have no staging: each one takes effect as soon as it is written.

Top module: `mtimer_top`

## Requirements
- R1: After reset the time value reads 0, both deadline words read 0xFFFFFFFF, no staged counter half is pending, and the interrupt request is low.
- R2: In the memory-mapped build, the counter low word is at byte address 0x0200BFF8 and its high word at 0x0200BFFC. The deadline low word is at 0x02004000 and its high word at 0x02004004.
- R3: In the CSR build, CSR 0x7C0 is the counter low word and 0x7C1 the counter high word. CSR 0x7C2 is the deadline low word and 0x7C3 the deadline high word.
- R4: A write to one counter half leaves the visible time value unchanged. The 64-bit value is loaded in a single cycle on the clock edge that accepts the second half.
- R5: The counter halves may be written low-then-high or high-then-low. A second write to a half that is already staged replaces the staged data, and the block keeps waiting. After a load, no half stays staged, so one further half write loads nothing.
- R6: The time value increments by one on every clock edge where tick_en is high, with carry from the low word into the high word. A counter load on the same edge wins over the increment.
- R7: timer_irq is high exactly while the time value, taken as an unsigned 64-bit number, is greater than or equal to the deadline. It follows every change of either register.
- R8: A write to one deadline word changes that word on the next edge and leaves the other word as it was.
- R9: With the read strobe high, read data is the live content of the addressed word. Read data is 0 while the read strobe is low.
- R10: A read of any address or CSR number outside the four mapped words returns 0. A write to one changes neither register and stages nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| tick_en | input | 1 | Advance the time value by one on this edge |
| mem_addr | input | 32 | Byte address of the memory-mapped port |
| mem_wdata | input | 32 | Write data of the memory-mapped port |
| mem_we | input | 1 | Write strobe of the memory-mapped port |
| mem_re | input | 1 | Read strobe of the memory-mapped port |
| mem_rdata | output | 32 | Read data of the memory-mapped port (0 in the CSR build) |
| csr_num | input | 12 | CSR number of the CSR port |
| csr_wdata | input | 32 | Write data of the CSR port |
| csr_we | input | 1 | Write strobe of the CSR port |
| csr_re | input | 1 | Read strobe of the CSR port |
| csr_rdata | output | 32 | Read data of the CSR port (0 in the memory-mapped build) |
| timer_irq | output | 1 | Machine timer interrupt request, level |

## Verification
A memory-mapped build and a CSR build get the same operation sequence, and their answers must match word for word, which separates the two address decodes. The counter load sequences cover low-then-high, high-then-low, a repeated half before its partner, and a lone half after a load. Together they separate a correct staging scheme from one that loads early, keeps the older data, or leaves a pending flag set. The deadline is set below, equal to and above the time value. A value whose high bit is set tests for a signed compare. Ticking across 0xFFFFFFFF tests the carry, and a tick on the edge of a load shows which of the two wins.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

  // Which software port the build decodes.
  typedef enum logic {
    MAP_MEM = 1'b0,
    MAP_CSR = 1'b1
  } map_e;

  // Register word picked by the port decoder.
  typedef enum logic [2:0] {
    SEL_NONE   = 3'd0,
    SEL_CNT_LO = 3'd1,
    SEL_CNT_HI = 3'd2,
    SEL_CMP_LO = 3'd3,
    SEL_CMP_HI = 3'd4
  } tsel_e;

endpackage

// File: rtl/mtimer_port_dec.sv
module mtimer_port_dec
  import mtimer_pkg::*;
#(
  parameter map_e                 MAP      = MAP_MEM,
  parameter int unsigned          ADDR_W   = 32,
  parameter int unsigned          CSR_W    = 12,
  parameter logic [ADDR_W-1:0]    CNT_BASE = 32'h0200_BFF8,
  parameter logic [ADDR_W-1:0]    CMP_BASE = 32'h0200_4000,
  parameter logic [CSR_W-1:0]     CSR_BASE = 12'h7C0
) (
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_we,
  input  logic              mem_re,
  input  logic [CSR_W-1:0]  csr_num,
  input  logic              csr_we,
  input  logic              csr_re,
  output tsel_e             sel,
  output logic              wr,
  output logic              rd
);

  localparam int unsigned WORD_BYTES = 4;

  // Address of the high word, one 32-bit word above the low word.
  function automatic logic [ADDR_W-1:0] hi_addr(input logic [ADDR_W-1:0] lo);
    return lo + ADDR_W'(WORD_BYTES);
  endfunction

  function automatic tsel_e mem_decode(input logic [ADDR_W-1:0] a);
    if (a == CNT_BASE)               return SEL_CNT_LO;
    else if (a == hi_addr(CNT_BASE)) return SEL_CNT_HI;
    else if (a == CMP_BASE)          return SEL_CMP_LO;
    else if (a == hi_addr(CMP_BASE)) return SEL_CMP_HI;
    else                             return SEL_NONE;
  endfunction

  function automatic tsel_e csr_decode(input logic [CSR_W-1:0] n);
    if (n == CSR_BASE)                        return SEL_CNT_LO;
    else if (n == CSR_BASE + CSR_W'(1))       return SEL_CNT_HI;
    else if (n == CSR_BASE + CSR_W'(2))       return SEL_CMP_LO;
    else if (n == CSR_BASE + CSR_W'(3))       return SEL_CMP_HI;
    else                                      return SEL_NONE;
  endfunction

  generate
    if (MAP == MAP_MEM) begin : g_mem
      logic unused_csr_bits;
      assign unused_csr_bits = ^{csr_num, csr_we, csr_re};
      assign sel = mem_decode(mem_addr);
      assign wr  = mem_we;
      assign rd  = mem_re;
    end else begin : g_csr
      logic unused_mem_bits;
      assign unused_mem_bits = ^{mem_addr, mem_we, mem_re};
      assign sel = csr_decode(csr_num);
      assign wr  = csr_we;
      assign rd  = csr_re;
    end
  endgenerate

endmodule

// File: rtl/mtimer_count.sv
module mtimer_count #(
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [DATA_W-1:0]   wdata,
  output logic [2*DATA_W-1:0] count,
  output logic                commit,
  output logic [1:0]          staged
);

  localparam int unsigned TW = 2 * DATA_W;

  logic              lo_pend, hi_pend;
  logic [DATA_W-1:0] lo_buf, hi_buf;
  logic [TW-1:0]     load_val;

  function automatic logic [TW-1:0] bump(input logic [TW-1:0] v);
    return v + TW'(1);
  endfunction

  // The second half completes the pair, whichever half it is.
  always_comb begin
    commit   = (wr_lo && hi_pend) || (wr_hi && lo_pend);
    load_val = {(wr_hi ? wdata : hi_buf), (wr_lo ? wdata : lo_buf)};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      lo_pend <= 1'b0;
      hi_pend <= 1'b0;
      lo_buf  <= '0;
      hi_buf  <= '0;
    end else if (commit) begin
      count   <= load_val;
      lo_pend <= 1'b0;
      hi_pend <= 1'b0;
    end else begin
      if (tick_en) count <= bump(count);
      if (wr_lo) begin
        lo_buf  <= wdata;
        lo_pend <= 1'b1;
      end
      if (wr_hi) begin
        hi_buf  <= wdata;
        hi_pend <= 1'b1;
      end
    end
  end

  assign staged = {hi_pend, lo_pend};

endmodule

// File: rtl/mtimer_compare.sv
module mtimer_compare #(
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [2*DATA_W-1:0] count,
  output logic [2*DATA_W-1:0] cmp,
  output logic                irq
);

  localparam int unsigned TW = 2 * DATA_W;

  // Unsigned "deadline reached" test.
  function automatic logic reached(input logic [TW-1:0] now, input logic [TW-1:0] dl);
    return now >= dl;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp <= '1;
    end else begin
      if (wr_lo) cmp[DATA_W-1:0]  <= wdata;
      if (wr_hi) cmp[TW-1:DATA_W] <= wdata;
    end
  end

  assign irq = reached(count, cmp);

endmodule

// File: rtl/mtimer_top.sv
module mtimer_top
  import mtimer_pkg::*;
#(
  parameter map_e              MAP      = MAP_MEM,
  parameter int unsigned       DATA_W   = 32,
  parameter int unsigned       ADDR_W   = 32,
  parameter int unsigned       CSR_W    = 12,
  parameter logic [ADDR_W-1:0] CNT_BASE = 32'h0200_BFF8,
  parameter logic [ADDR_W-1:0] CMP_BASE = 32'h0200_4000,
  parameter logic [CSR_W-1:0]  CSR_BASE = 12'h7C0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_we,
  input  logic              mem_re,
  output logic [DATA_W-1:0] mem_rdata,
  input  logic [CSR_W-1:0]  csr_num,
  input  logic [DATA_W-1:0] csr_wdata,
  input  logic              csr_we,
  input  logic              csr_re,
  output logic [DATA_W-1:0] csr_rdata,
  output logic              timer_irq
);

  localparam int unsigned TW = 2 * DATA_W;

  tsel_e             sel;
  logic              wr, rd;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rd_word;
  logic [TW-1:0]     count, cmp;
  logic              commit;
  logic [1:0]        staged;
  logic              cnt_wr_lo, cnt_wr_hi, cmp_wr_lo, cmp_wr_hi;

  mtimer_port_dec #(
    .MAP      (MAP),
    .ADDR_W   (ADDR_W),
    .CSR_W    (CSR_W),
    .CNT_BASE (CNT_BASE),
    .CMP_BASE (CMP_BASE),
    .CSR_BASE (CSR_BASE)
  ) dec_i (
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .csr_num  (csr_num),
    .csr_we   (csr_we),
    .csr_re   (csr_re),
    .sel      (sel),
    .wr       (wr),
    .rd       (rd)
  );

  assign cnt_wr_lo = wr && (sel == SEL_CNT_LO);
  assign cnt_wr_hi = wr && (sel == SEL_CNT_HI);
  assign cmp_wr_lo = wr && (sel == SEL_CMP_LO);
  assign cmp_wr_hi = wr && (sel == SEL_CMP_HI);

  mtimer_count #(.DATA_W(DATA_W)) cnt_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .wr_lo   (cnt_wr_lo),
    .wr_hi   (cnt_wr_hi),
    .wdata   (wdata),
    .count   (count),
    .commit  (commit),
    .staged  (staged)
  );

  mtimer_compare #(.DATA_W(DATA_W)) cmp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_lo   (cmp_wr_lo),
    .wr_hi   (cmp_wr_hi),
    .wdata   (wdata),
    .count   (count),
    .cmp     (cmp),
    .irq     (timer_irq)
  );

  // Live word selected by the decoder; zero for unmapped words.
  function automatic logic [DATA_W-1:0] pick_word(input tsel_e s,
                                                  input logic [TW-1:0] c,
                                                  input logic [TW-1:0] m);
    case (s)
      SEL_CNT_LO: return c[DATA_W-1:0];
      SEL_CNT_HI: return c[TW-1:DATA_W];
      SEL_CMP_LO: return m[DATA_W-1:0];
      SEL_CMP_HI: return m[TW-1:DATA_W];
      default:    return '0;
    endcase
  endfunction

  assign rd_word = rd ? pick_word(sel, count, cmp) : '0;

  generate
    if (MAP == MAP_MEM) begin : g_out_mem
      logic unused_csr_wdata;
      assign unused_csr_wdata = ^csr_wdata;
      assign wdata     = mem_wdata;
      assign mem_rdata = rd_word;
      assign csr_rdata = '0;
    end else begin : g_out_csr
      logic unused_mem_wdata;
      assign unused_mem_wdata = ^mem_wdata;
      assign wdata     = csr_wdata;
      assign csr_rdata = rd_word;
      assign mem_rdata = '0;
    end
  endgenerate

endmodule

// File: rtl/mtimer_checker.sv
module mtimer_checker
  import mtimer_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick_en,
  input logic                wr,
  input logic                rd,
  input tsel_e               sel,
  input logic [DATA_W-1:0]   wdata,
  input logic [DATA_W-1:0]   rd_word,
  input logic [2*DATA_W-1:0] count,
  input logic [2*DATA_W-1:0] cmp,
  input logic                commit,
  input logic [1:0]          staged
);

  localparam int unsigned TW = 2 * DATA_W;

  // R4: with no load and no tick the time value holds.
  assert_hold_without_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !tick_en) |=> $stable(count));

  // R6: a tick without a load adds exactly one.
  assert_tick_adds_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && tick_en) |=> (count == $past(count) + TW'(1)));

  // R5: after a load nothing stays staged.
  assert_flags_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (staged == 2'b00));

  // R5: both halves are never pending at once.
  assert_one_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(staged));

  // R8: a deadline high-word write lands alone.
  assert_cmp_hi_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_CMP_HI) |=>
      (cmp[TW-1:DATA_W] == $past(wdata)) && $stable(cmp[DATA_W-1:0]));

  // R8: a deadline low-word write lands alone.
  assert_cmp_lo_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_CMP_LO) |=>
      (cmp[DATA_W-1:0] == $past(wdata)) && $stable(cmp[TW-1:DATA_W]));

  // R10: unmapped reads return zero.
  assert_unmapped_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel == SEL_NONE) |-> (rd_word == '0));

  // R10: unmapped writes touch no state.
  assert_unmapped_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_NONE && !tick_en) |=>
      ($stable(count) && $stable(cmp) && $stable(staged)));

endmodule

bind mtimer_top mtimer_checker #(.DATA_W(DATA_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick_en (tick_en),
  .wr      (wr),
  .rd      (rd),
  .sel     (sel),
  .wdata   (wdata),
  .rd_word (rd_word),
  .count   (count),
  .cmp     (cmp),
  .commit  (commit),
  .staged  (staged)
);

// File: tb/mtimer_tb_top.sv
`timescale 1ns/1ps
module mtimer_top_tb_top;
  import mtimer_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [31:0] mem_addr = '0;
  logic [31:0] mem_wdata = '0;
  logic        mem_we = 1'b0;
  logic        mem_re = 1'b0;
  logic [11:0] csr_num = '0;
  logic [31:0] csr_wdata = '0;
  logic        csr_we = 1'b0;
  logic        csr_re = 1'b0;
  logic [31:0] m_mem_rdata, m_csr_rdata, c_mem_rdata, c_csr_rdata;
  logic        m_irq, c_irq;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  mtimer_top #(.MAP(MAP_MEM)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(m_mem_rdata),
    .csr_num(csr_num), .csr_wdata(csr_wdata), .csr_we(csr_we), .csr_re(csr_re),
    .csr_rdata(m_csr_rdata), .timer_irq(m_irq)
  );

  mtimer_top #(.MAP(MAP_CSR)) dut_csr_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(c_mem_rdata),
    .csr_num(csr_num), .csr_wdata(csr_wdata), .csr_we(csr_we), .csr_re(csr_re),
    .csr_rdata(c_csr_rdata), .timer_irq(c_irq)
  );

  // Word index: 0 cnt lo, 1 cnt hi, 2 cmp lo, 3 cmp hi, 4 unmapped (R2, R3 maps).
  function automatic logic [31:0] maddr(input int w);
    case (w)
      0: return 32'h0200_BFF8;
      1: return 32'h0200_BFFC;
      2: return 32'h0200_4000;
      3: return 32'h0200_4004;
      default: return 32'h0200_4008;
    endcase
  endfunction

  function automatic logic [11:0] cnum(input int w);
    return 12'h7C0 + 12'(w);
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr_word(input int w, input logic [31:0] d);
    @(negedge clk);
    mem_addr = maddr(w); csr_num = cnum(w);
    mem_wdata = d; csr_wdata = d;
    mem_we = 1'b1; csr_we = 1'b1;
    @(negedge clk);
    mem_we = 1'b0; csr_we = 1'b0;
  endtask

  task automatic rd_check(input int w, input logic [31:0] exp, input string req);
    @(negedge clk);
    mem_addr = maddr(w); csr_num = cnum(w);
    mem_re = 1'b1; csr_re = 1'b1;
    #1;
    check(req, "memory-mapped build read", m_mem_rdata, exp);
    check(req, "CSR build read", c_csr_rdata, exp);
    check(req, "idle port of memory build", m_csr_rdata, 32'h0);
    mem_re = 1'b0; csr_re = 1'b0;
  endtask

  task automatic irq_check(input logic exp, input string req);
    @(negedge clk); #1;
    check(req, "irq memory build", {31'h0, m_irq}, {31'h0, exp});
    check(req, "irq CSR build", {31'h0, c_irq}, {31'h0, exp});
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  // Fields: kind[40:39] (0 write, 1 read, 2 irq), req[38:35], word[34:32], data[31:0].
  localparam int NV = 39;
  localparam logic [40:0] VEC [0:NV-1] = '{
    {2'd1, 4'd1, 3'd0, 32'h0000_0000},  // R1 count lo
    {2'd1, 4'd1, 3'd1, 32'h0000_0000},  // R1 count hi
    {2'd1, 4'd1, 3'd2, 32'hFFFF_FFFF},  // R1 deadline lo
    {2'd1, 4'd1, 3'd3, 32'hFFFF_FFFF},  // R1 deadline hi
    {2'd2, 4'd1, 3'd0, 32'h0000_0000},  // R1 irq low
    {2'd0, 4'd4, 3'd0, 32'h1111_1111},  // R4 stage lo
    {2'd1, 4'd4, 3'd0, 32'h0000_0000},  // R4 not visible
    {2'd0, 4'd5, 3'd0, 32'h2222_2222},  // R5 replace staged lo
    {2'd1, 4'd5, 3'd0, 32'h0000_0000},  // R5 still waiting
    {2'd0, 4'd4, 3'd1, 32'h0000_0003},  // R4 hi completes
    {2'd1, 4'd4, 3'd0, 32'h2222_2222},  // R4 newer lo loaded
    {2'd1, 4'd4, 3'd1, 32'h0000_0003},  // R4
    {2'd0, 4'd5, 3'd1, 32'h0000_0005},  // R5 hi first
    {2'd1, 4'd5, 3'd1, 32'h0000_0003},  // R5 not yet
    {2'd0, 4'd5, 3'd0, 32'h0000_0006},  // R5 lo completes
    {2'd1, 4'd5, 3'd0, 32'h0000_0006},  // R5
    {2'd1, 4'd5, 3'd1, 32'h0000_0005},  // R5
    {2'd0, 4'd8, 3'd2, 32'h0000_0010},  // R8 deadline lo
    {2'd1, 4'd8, 3'd2, 32'h0000_0010},  // R8
    {2'd1, 4'd8, 3'd3, 32'hFFFF_FFFF},  // R8 hi untouched
    {2'd0, 4'd8, 3'd3, 32'h0000_0005},  // R8 deadline hi
    {2'd1, 4'd8, 3'd3, 32'h0000_0005},  // R8
    {2'd2, 4'd7, 3'd0, 32'h0000_0000},  // R7 below deadline
    {2'd0, 4'd7, 3'd2, 32'h0000_0006},  // R7 deadline equal
    {2'd2, 4'd7, 3'd0, 32'h0000_0001},  // R7
    {2'd0, 4'd7, 3'd2, 32'h0000_0007},  // R7 deadline above
    {2'd2, 4'd7, 3'd0, 32'h0000_0000},  // R7
    {2'd1, 4'd10, 3'd4, 32'h0000_0000}, // R10 unmapped read
    {2'd0, 4'd10, 3'd4, 32'hDEAD_BEEF}, // R10 unmapped write
    {2'd1, 4'd10, 3'd0, 32'h0000_0006}, // R10 nothing moved
    {2'd1, 4'd10, 3'd1, 32'h0000_0005}, // R10
    {2'd1, 4'd10, 3'd2, 32'h0000_0007}, // R10
    {2'd1, 4'd10, 3'd3, 32'h0000_0005}, // R10
    {2'd0, 4'd5, 3'd0, 32'h0000_000A},  // R5 lone half after load
    {2'd1, 4'd5, 3'd0, 32'h0000_0006},  // R5 no load
    {2'd0, 4'd5, 3'd1, 32'h0000_0000},  // R5 partner completes
    {2'd1, 4'd5, 3'd0, 32'h0000_000A},  // R5
    {2'd1, 4'd5, 3'd1, 32'h0000_0000},  // R5
    {2'd2, 4'd7, 3'd0, 32'h0000_0000}   // R7 irq low again
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Table walk, ticks off; both builds see identical traffic (R2, R3).
    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", VEC[i][38:35]);
      case (VEC[i][40:39])
        2'd0: wr_word(int'(VEC[i][34:32]), VEC[i][31:0]);
        2'd1: rd_check(int'(VEC[i][34:32]), VEC[i][31:0], rq);
        default: irq_check(VEC[i][0], rq);
      endcase
    end

    // R6: carry from low into high word.
    wr_word(0, 32'hFFFF_FFFE);
    wr_word(1, 32'h0000_0000);
    ticks(3);
    rd_check(0, 32'h0000_0001, "R6");
    rd_check(1, 32'h0000_0001, "R6");

    // R6: load wins over a tick on the same edge.
    @(negedge clk); tick_en = 1'b1;
    wr_word(0, 32'h0000_0100);
    wr_word(1, 32'h0000_0000);
    tick_en = 1'b0;
    rd_check(0, 32'h0000_0100, "R6");
    rd_check(1, 32'h0000_0000, "R6");

    // R7: deadline reached by ticking, stays high as a level.
    wr_word(3, 32'h0000_0000);
    wr_word(2, 32'h0000_0102);
    irq_check(1'b0, "R7");
    ticks(1);
    irq_check(1'b0, "R7");
    ticks(1);
    irq_check(1'b1, "R7");
    ticks(1);
    irq_check(1'b1, "R7");

    // R7: unsigned compare with the top bit set.
    wr_word(1, 32'h8000_0000);
    wr_word(0, 32'h0000_0000);
    irq_check(1'b1, "R7");
    wr_word(3, 32'hFFFF_FFFF);
    irq_check(1'b0, "R7");

    // R9: read strobe low gives zero.
    @(negedge clk);
    mem_addr = maddr(1); csr_num = cnum(1);
    mem_re = 1'b0; csr_re = 1'b0;
    #1;
    check("R9", "strobe low memory build", m_mem_rdata, 32'h0);
    check("R9", "strobe low CSR build", c_csr_rdata, 32'h0);

    // R1: reset clears a staged half and restores defaults.
    wr_word(0, 32'h0000_0055);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_check(0, 32'h0000_0000, "R1");
    rd_check(3, 32'hFFFF_FFFF, "R1");
    irq_check(1'b0, "R1");
    wr_word(1, 32'h0000_0009);
    rd_check(1, 32'h0000_0000, "R1");
    rd_check(0, 32'h0000_0000, "R1");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #600000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule